// File: doc/BRIEF.md
# One-Shot Target Time Comparator

This block watches a running seconds/nanoseconds timestamp and raises a single event when that time reaches a programmed target. The target is held as a seconds word and a nanoseconds word. Seconds are the most significant part of the comparison, and both words are compared as unsigned values. Software arms the comparator by writing its arm bit. Hardware drops the arm bit on the edge that raises the event, so each arming produces one event and no more.

Each event sets a sticky status flag. Software clears the flag by writing a one to it. A separate interrupt-enable input masks the interrupt output. The block does not generate the timestamp; it only samples the live value on its inputs.

Top module: `target_time_cmp`

## Requirements
- R1: When the arm bit is set at a clock edge and {sec_i, ns_i} >= {tgt_sec_i, tgt_ns_i} (unsigned, seconds most significant), hit_o is 1 in the following cycle. The match is taken on the first such edge, including the equal case.
- R2: While the arm bit is clear, hit_o stays 0 and the status flag is not set, whatever the timestamp is.
- R3: The arm bit (armed_o) clears on the same edge that raises hit_o, unless software sets it on that edge.
- R4: hit_o is one clock wide for each arming; it is 0 in the cycle after a pulse even if the timestamp is still at or past the target.
- R5: An event sets sts_o, and sts_o stays set until it is cleared. A status write (sts_we_i = 1) with sts_wdata_i = 1 clears it. A status write with sts_wdata_i = 0 has no effect.
- R6: irq_o is sts_o ANDed with irq_en_i.
- R7: If a status clear and an event occur on the same edge, the event wins and sts_o stays 1.
- R8: An arm write (arm_we_i = 1) loads arm_wdata_i into the arm bit, and this write takes priority over the hardware clear. A write of 1 on the event edge leaves armed_o at 1. A write of 0 disarms.
- R9: After reset, armed_o, hit_o, sts_o and irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_i | input | SEC_W | Live timestamp, seconds |
| ns_i | input | NS_W | Live timestamp, nanoseconds |
| tgt_sec_i | input | SEC_W | Target seconds |
| tgt_ns_i | input | NS_W | Target nanoseconds |
| arm_we_i | input | 1 | Arm bit write strobe |
| arm_wdata_i | input | 1 | Value written to the arm bit |
| sts_we_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 1 | Status write data, 1 clears |
| irq_en_i | input | 1 | Interrupt enable |
| armed_o | output | 1 | Current arm bit |
| hit_o | output | 1 | One-cycle compare event |
| sts_o | output | 1 | Sticky event status |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest situations to reach are the two same-edge collisions. One is a status clear landing on the very edge an event fires. The other is a software re-arm landing on the edge where hardware drops the arm bit. The bench reaches both by arming while the timestamp is still below the target. It then steps the timestamp past the target in the same half-cycle that it drives the clear or arm write, which fixes the edge of the event exactly. Word-boundary comparisons (equal, one below, seconds dominating nanoseconds, top-bit unsigned) come from a vector table.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int unsigned DEF_SEC_W = 32;
  localparam int unsigned DEF_NS_W  = 32;

  typedef enum logic [1:0] {
    ARM_HOLD = 2'd0,
    ARM_SW   = 2'd1,
    ARM_HWC  = 2'd2
  } arm_op_e;

  typedef enum logic [1:0] {
    STS_HOLD = 2'd0,
    STS_SET  = 2'd1,
    STS_CLR  = 2'd2
  } sts_op_e;
endpackage

// File: rtl/tcmp_ge.sv
module tcmp_ge #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned NS_W  = 32,
  parameter bit          SPLIT = 1'b1
) (
  input  logic [SEC_W-1:0] sec_i,
  input  logic [NS_W-1:0]  ns_i,
  input  logic [SEC_W-1:0] tgt_sec_i,
  input  logic [NS_W-1:0]  tgt_ns_i,
  output logic             ge_o
);
  localparam int unsigned TW = SEC_W + NS_W;

  generate
    if (SPLIT) begin : g_split
      // per-word compare keeps carry chains short
      logic sec_gt, sec_eq, ns_ge;
      always_comb begin
        sec_gt = sec_i > tgt_sec_i;
        sec_eq = sec_i == tgt_sec_i;
        ns_ge  = ns_i >= tgt_ns_i;
        ge_o   = sec_gt | (sec_eq & ns_ge);
      end
    end else begin : g_flat
      logic [TW-1:0] now_w, tgt_w;
      always_comb begin
        now_w = {sec_i, ns_i};
        tgt_w = {tgt_sec_i, tgt_ns_i};
        ge_o  = now_w >= tgt_w;
      end
    end
  endgenerate
endmodule

// File: rtl/tcmp_arm.sv
module tcmp_arm
  import tcmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wdata_i,
  input  logic ge_i,
  output logic armed_o,
  output logic fire_o,
  output logic hit_o
);
  arm_op_e op;
  logic    armed_q, hit_q;

  assign fire_o = armed_q & ge_i;

  always_comb begin
    if (we_i)        op = ARM_SW;
    else if (fire_o) op = ARM_HWC;
    else             op = ARM_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      hit_q <= fire_o;
      unique case (op)
        ARM_SW:  armed_q <= wdata_i;
        ARM_HWC: armed_q <= 1'b0;
        default: armed_q <= armed_q;
      endcase
    end
  end

  assign armed_o = armed_q;
  assign hit_o   = hit_q;
endmodule

// File: rtl/tcmp_flag.sv
module tcmp_flag
  import tcmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic we_i,
  input  logic wdata_i,
  input  logic irq_en_i,
  output logic sts_o,
  output logic irq_o
);
  sts_op_e op;
  logic    sts_q;

  always_comb begin
    if (set_i)               op = STS_SET;
    else if (we_i && wdata_i) op = STS_CLR;
    else                     op = STS_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= 1'b0;
    else begin
      unique case (op)
        STS_SET: sts_q <= 1'b1;
        STS_CLR: sts_q <= 1'b0;
        default: sts_q <= sts_q;
      endcase
    end
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q & irq_en_i;
endmodule

// File: rtl/target_time_cmp.sv
module target_time_cmp
  import tcmp_pkg::*;
#(
  parameter int unsigned SEC_W = DEF_SEC_W,
  parameter int unsigned NS_W  = DEF_NS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [NS_W-1:0]  ns_i,
  input  logic [SEC_W-1:0] tgt_sec_i,
  input  logic [NS_W-1:0]  tgt_ns_i,
  input  logic             arm_we_i,
  input  logic             arm_wdata_i,
  input  logic             sts_we_i,
  input  logic             sts_wdata_i,
  input  logic             irq_en_i,
  output logic             armed_o,
  output logic             hit_o,
  output logic             sts_o,
  output logic             irq_o
);
  logic ge, fire;

  tcmp_ge #(.SEC_W(SEC_W), .NS_W(NS_W), .SPLIT(1'b1)) u_ge (
    .sec_i(sec_i), .ns_i(ns_i), .tgt_sec_i(tgt_sec_i), .tgt_ns_i(tgt_ns_i),
    .ge_o(ge)
  );

  tcmp_arm u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(arm_we_i), .wdata_i(arm_wdata_i),
    .ge_i(ge), .armed_o(armed_o), .fire_o(fire), .hit_o(hit_o)
  );

  tcmp_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(fire), .we_i(sts_we_i),
    .wdata_i(sts_wdata_i), .irq_en_i(irq_en_i), .sts_o(sts_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/target_time_cmp_chk.sv
module target_time_cmp_chk #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned NS_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEC_W-1:0] sec_i,
  input logic [NS_W-1:0]  ns_i,
  input logic [SEC_W-1:0] tgt_sec_i,
  input logic [NS_W-1:0]  tgt_ns_i,
  input logic             arm_we_i,
  input logic             arm_wdata_i,
  input logic             sts_we_i,
  input logic             sts_wdata_i,
  input logic             irq_en_i,
  input logic             armed_o,
  input logic             hit_o,
  input logic             sts_o,
  input logic             irq_o
);
  logic reached;
  assign reached = {sec_i, ns_i} >= {tgt_sec_i, tgt_ns_i};

  assert_fire_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && reached) |=> hit_o);

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_o |=> !hit_o);

  assert_selfclr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> (!armed_o || $past(arm_we_i && arm_wdata_i)));

  assert_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !(arm_we_i && arm_wdata_i)) |=> !hit_o);

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o && !(sts_we_i && sts_wdata_i)) |=> sts_o);

  assert_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && sts_wdata_i && !(armed_o && reached)) |=> !sts_o);

  assert_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_o |-> !irq_o);

  assert_evwins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> sts_o);
endmodule

bind target_time_cmp target_time_cmp_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sec_i(sec_i), .ns_i(ns_i),
  .tgt_sec_i(tgt_sec_i), .tgt_ns_i(tgt_ns_i), .arm_we_i(arm_we_i),
  .arm_wdata_i(arm_wdata_i), .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i),
  .irq_en_i(irq_en_i), .armed_o(armed_o), .hit_o(hit_o), .sts_o(sts_o),
  .irq_o(irq_o)
);

// File: tb/target_time_cmp_bench.sv
module target_time_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] sec = '0, ns = '0, tsec = '0, tns = '0;
  logic        arm_we = 0, arm_wd = 0, sts_we = 0, sts_wd = 0, irq_en = 0;
  logic        armed, hit, sts, irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  target_time_cmp u_target_time_cmp (
    .clk_i(clk), .rst_ni(rst_ni), .sec_i(sec), .ns_i(ns), .tgt_sec_i(tsec),
    .tgt_ns_i(tns), .arm_we_i(arm_we), .arm_wdata_i(arm_wd), .sts_we_i(sts_we),
    .sts_wdata_i(sts_wd), .irq_en_i(irq_en), .armed_o(armed), .hit_o(hit),
    .sts_o(sts), .irq_o(irq)
  );

  // {sec, ns, tgt_sec, tgt_ns, expect_hit}
  localparam logic [128:0] VEC [8] = '{
    {32'd5, 32'd100, 32'd5, 32'd100, 1'b1},
    {32'd5, 32'd99, 32'd5, 32'd100, 1'b0},
    {32'd6, 32'd0, 32'd5, 32'd999, 1'b1},
    {32'd4, 32'd999999999, 32'd5, 32'd0, 1'b0},
    {32'd0, 32'd0, 32'd0, 32'd0, 1'b1},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b1},
    {32'd7, 32'd5, 32'd7, 32'd6, 1'b0},
    {32'h80000000, 32'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    cyc(); cyc();
    chk("R9 armed", armed, 0); chk("R9 hit", hit, 0);
    chk("R9 sts", sts, 0);     chk("R9 irq", irq, 0);
    rst_ni = 1;
    cyc();

    foreach (VEC[i]) begin
      {sec, ns, tsec, tns} = VEC[i][128:1];
      cyc();
      arm_we = 1; arm_wd = 1;
      cyc();
      arm_we = 0;
      cyc();
      chk($sformatf("R1 hit vec%0d", i), hit, VEC[i][0]);
      chk($sformatf("R3 armed vec%0d", i), armed, !VEC[i][0]);
      chk($sformatf("R5 sts vec%0d", i), sts, VEC[i][0]);
      arm_we = 1; arm_wd = 0; sts_we = 1; sts_wd = 1;
      cyc();
      arm_we = 0; sts_we = 0;
    end

    // R2: disarmed, timestamp past target
    sec = 10; ns = 900; tsec = 10; tns = 500;
    repeat (4) cyc();
    chk("R2 hit idle", hit, 0); chk("R2 sts idle", sts, 0);

    // R1 first reaching edge, then R3/R4/R5/R6
    ns = 400;
    arm_we = 1; arm_wd = 1; cyc(); arm_we = 0;
    repeat (3) cyc();
    chk("R1 below target", hit, 0); chk("R1 still armed", armed, 1);
    ns = 500; cyc();
    ns = 501;
    chk("R1 equal fires", hit, 1); chk("R3 cleared", armed, 0);
    cyc();
    chk("R4 one wide", hit, 0); chk("R5 sticky", sts, 1);
    chk("R6 masked", irq, 0);
    irq_en = 1; #1;
    chk("R6 unmasked", irq, 1);
    sts_we = 1; sts_wd = 0; cyc(); sts_we = 0;
    chk("R5 write0 ignored", sts, 1);

    // R7: clear collides with event
    ns = 400;
    arm_we = 1; arm_wd = 1; cyc(); arm_we = 0;
    ns = 600; sts_we = 1; sts_wd = 1; cyc(); sts_we = 0;
    chk("R7 hit", hit, 1); chk("R7 sts kept", sts, 1);

    // R8: sw set collides with hw clear
    ns = 400;
    arm_we = 1; arm_wd = 1; cyc(); arm_we = 0;
    ns = 600; arm_we = 1; arm_wd = 1; cyc(); arm_we = 0;
    chk("R8 hit", hit, 1); chk("R8 armed kept", armed, 1);
    ns = 400; arm_we = 1; arm_wd = 0; cyc(); arm_we = 0;
    chk("R8 write0 disarms", armed, 0);
    ns = 600; cyc(); cyc();
    chk("R8 no hit after disarm", hit, 0);
    sts_we = 1; sts_wd = 1; cyc(); sts_we = 0;
    chk("R5 w1c", sts, 0); chk("R6 irq low", irq, 0);

    finish_run();
  end
endmodule